// File: doc/BRIEF.md
# Transmit Gearbox Sequence Controller

This block drives the transmit side of a serial transceiver gearbox that has no internal sequence counter of its own. It generates the sequence value for the gearbox and tells the upstream data source whether it may present a new word. It also registers the data word and block header that go to the gearbox, together with that sequence value. Two framings are supported on a 2-byte user interface: 64B/66B, with a 2-bit header and sequence values 0 to 32, and 64B/67B, with a 3-bit header and sequence values 0 to 66.

Each sequence value lasts two user clock cycles, so four bytes are accepted per value. At fixed sequence values the gearbox must drop the input for one full value while its internal phase catches up. During those values the ready output is low. The registered data and header are held, so anything the source drives in that window never reaches the gearbox. A new header is taken in on the first cycle of every second data-carrying sequence value, which gives one header per eight-byte block.

Each output tuple (sequence, data, header) appears one clock after the cycle in which ready was shown and the source drove its word. The framing select is captured only while reset is high.

Top module: `gbx_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `seq_o` = 0 and `ready_o` = 1. `data_o` takes `up_data_i`, and `hdr_o` takes `up_hdr_i`, masked as in R7 by the framing select present at that edge.
- R2: After reset, `seq_o` shows the internal count one cycle late. Each value is held for exactly two cycles and then steps up by one.
- R3: `seq_o` wraps to 0 after its last value: 66 when `mode_sel_i` = 1 (64B/67B) and 32 when `mode_sel_i` = 0 (64B/66B). The whole pattern then repeats.
- R4: `ready_o` is low for both cycles of a pause count and high otherwise. The pause counts are 21, 44 and 65 in 64B/67B, and 31 in 64B/66B. `ready_o` low in one cycle is followed by `seq_o` showing that pause count in the next.
- R5: A word driven while `ready_o` is low is ignored. `data_o` and `hdr_o` stay unchanged in the following cycle.
- R6: On a non-pause count, `data_o` takes `up_data_i` in both cycles. `hdr_o` takes `up_hdr_i` only in the first cycle of every second non-pause count, counting from count 0 after reset or wrap. This includes counts 0, 2 and 4.
- R7: In 64B/66B mode, bit 2 of `hdr_o` is forced to 0 and only bits 1:0 are carried. In 64B/67B mode all three bits are carried.
- R8: `mode_sel_i` is sampled only while `rst` is high. Changing it outside reset has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, may be held indefinitely |
| mode_sel_i | input | 1 | Framing select: 1 = 64B/67B, 0 = 64B/66B |
| up_data_i | input | 16 | Data word from the upstream source |
| up_hdr_i | input | 3 | Block header from the upstream source |
| seq_o | output | 7 | Sequence value to the gearbox |
| data_o | output | 16 | Data word to the gearbox |
| hdr_o | output | 3 | Header to the gearbox |
| ready_o | output | 1 | High when the source may present a new word |

## Verification
The source keeps driving fresh random words straight through every pause. A design that sampled during a pause, or left ready high there, would show a changed `data_o` or `hdr_o` one cycle later.

Header capture is tracked by the count of data-carrying values rather than by the raw count. A design that keyed headers to even counts would take headers at the wrong places after count 21 in 64B/67B.

The framing select is toggled at random outside reset. A design that read it live would wrap at the wrong count or mask the header wrongly.

Both wrap points are crossed several times. Reset is also held for a long stretch while data changes, and is reapplied in both framings.

// File: rtl/gbx_seq_pkg.sv
package gbx_seq_pkg;

  localparam int SEQ_W  = 7;
  localparam int HDR_W  = 3;
  localparam int DATA_W = 16;

  typedef enum logic {
    FRAME_66 = 1'b0,
    FRAME_67 = 1'b1
  } frame_e;

  // Last sequence value before the wrap to zero.
  function automatic logic [SEQ_W-1:0] last_count(frame_e m);
    return (m == FRAME_67) ? SEQ_W'(66) : SEQ_W'(32);
  endfunction

  // Sequence values on which the gearbox drops its input.
  function automatic logic is_pause(frame_e m, logic [SEQ_W-1:0] c);
    if (m == FRAME_67)
      return (c == SEQ_W'(21)) || (c == SEQ_W'(44)) || (c == SEQ_W'(65));
    else
      return (c == SEQ_W'(31));
  endfunction

endpackage

// File: rtl/gbx_pause_dec.sv
module gbx_pause_dec
  import gbx_seq_pkg::*;
#(
  parameter int CNT_W = SEQ_W
) (
  input  frame_e           mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pause_o,
  output logic             last_o
);

  localparam int PAD_W = SEQ_W - CNT_W;

  logic [SEQ_W-1:0] cnt_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_ext = {{PAD_W{1'b0}}, cnt_i};
    end else begin : g_nopad
      assign cnt_ext = cnt_i[SEQ_W-1:0];
    end
  endgenerate

  always_comb begin
    pause_o = is_pause(mode_i, cnt_ext);
    last_o  = (cnt_ext == last_count(mode_i));
  end

endmodule

// File: rtl/gbx_seq_state.sv
module gbx_seq_state
  import gbx_seq_pkg::*;
#(
  parameter int CNT_W = SEQ_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel_i,
  input  logic             pause_i,
  input  logic             last_i,
  output frame_e           mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             phase_o,
  output logic             half_o
);

  logic wrap;
  logic half_next;

  always_comb begin
    wrap       = phase_o && last_i;
    cnt_next_o = cnt_o;
    if (phase_o)
      cnt_next_o = last_i ? '0 : cnt_o + CNT_W'(1);
    half_next = half_o;
    if (wrap)
      half_next = 1'b0;
    else if (phase_o && !pause_i)
      half_next = ~half_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= frame_e'(mode_sel_i);
      cnt_o   <= '0;
      phase_o <= 1'b0;
      half_o  <= 1'b0;
    end else begin
      cnt_o   <= cnt_next_o;
      phase_o <= ~phase_o;
      half_o  <= half_next;
    end
  end

endmodule

// File: rtl/gbx_seq_out.sv
module gbx_seq_out
  import gbx_seq_pkg::*;
#(
  parameter int CNT_W  = SEQ_W,
  parameter int D_W    = DATA_W,
  parameter int H_W    = HDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel_i,
  input  frame_e           mode_q_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             phase_i,
  input  logic             half_i,
  input  logic             pause_cur_i,
  input  logic             pause_next_i,
  input  logic [D_W-1:0]   up_data_i,
  input  logic [H_W-1:0]   up_hdr_i,
  output logic [CNT_W-1:0] seq_o,
  output logic [D_W-1:0]   data_o,
  output logic [H_W-1:0]   hdr_o,
  output logic             ready_o
);

  function automatic logic [H_W-1:0] mask_hdr(frame_e m, logic [H_W-1:0] h);
    logic [H_W-1:0] r;
    r = h;
    if (m == FRAME_66)
      r[H_W-1] = 1'b0;
    return r;
  endfunction

  logic accept;
  logic take_hdr;

  always_comb begin
    accept   = !pause_cur_i;
    take_hdr = accept && !phase_i && !half_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_o   <= '0;
      data_o  <= up_data_i;
      hdr_o   <= mask_hdr(frame_e'(mode_sel_i), up_hdr_i);
      ready_o <= 1'b1;
    end else begin
      seq_o   <= cnt_i;
      ready_o <= !pause_next_i;
      if (accept)
        data_o <= up_data_i;
      if (take_hdr)
        hdr_o <= mask_hdr(mode_q_i, up_hdr_i);
    end
  end

endmodule

// File: rtl/gbx_seq_ctrl.sv
module gbx_seq_ctrl
  import gbx_seq_pkg::*;
#(
  parameter int CNT_W = SEQ_W,
  parameter int D_W   = DATA_W,
  parameter int H_W   = HDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel_i,
  input  logic [D_W-1:0]   up_data_i,
  input  logic [H_W-1:0]   up_hdr_i,
  output logic [CNT_W-1:0] seq_o,
  output logic [D_W-1:0]   data_o,
  output logic [H_W-1:0]   hdr_o,
  output logic             ready_o
);

  frame_e           mode_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             phase;
  logic             half;
  logic             pause_cur;
  logic             last_cur;
  logic             pause_next;
  logic             last_next;

  gbx_pause_dec #(.CNT_W(CNT_W)) u_dec_cur (
    .mode_i  (mode_q),
    .cnt_i   (cnt),
    .pause_o (pause_cur),
    .last_o  (last_cur)
  );

  gbx_pause_dec #(.CNT_W(CNT_W)) u_dec_next (
    .mode_i  (mode_q),
    .cnt_i   (cnt_next),
    .pause_o (pause_next),
    .last_o  (last_next)
  );

  gbx_seq_state #(.CNT_W(CNT_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .mode_sel_i (mode_sel_i),
    .pause_i    (pause_cur),
    .last_i     (last_cur),
    .mode_o     (mode_q),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .phase_o    (phase),
    .half_o     (half)
  );

  gbx_seq_out #(.CNT_W(CNT_W), .D_W(D_W), .H_W(H_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .mode_sel_i   (mode_sel_i),
    .mode_q_i     (mode_q),
    .cnt_i        (cnt),
    .phase_i      (phase),
    .half_i       (half),
    .pause_cur_i  (pause_cur),
    .pause_next_i (pause_next),
    .up_data_i    (up_data_i),
    .up_hdr_i     (up_hdr_i),
    .seq_o        (seq_o),
    .data_o       (data_o),
    .hdr_o        (hdr_o),
    .ready_o      (ready_o)
  );

  logic unused_last_next;
  assign unused_last_next = last_next;

endmodule

// File: rtl/gbx_seq_ctrl_chk.sv
module gbx_seq_ctrl_chk #(
  parameter int CNT_W = 7,
  parameter int D_W   = 16,
  parameter int H_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] seq_o,
  input logic [D_W-1:0]   data_o,
  input logic [H_W-1:0]   hdr_o,
  input logic             ready_o
);

  // R1: the first cycle after reset shows count zero and ready.
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seq_o == '0) && ready_o);

  // R2: a new sequence value is held for one more cycle.
  assert_two_cycle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (seq_o != $past(seq_o))) |=> $stable(seq_o));

  // R3: the sequence either holds, steps by one or wraps to zero.
  assert_step_or_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_o != $past(seq_o)) |->
      ((seq_o == $past(seq_o) + CNT_W'(1)) || (seq_o == '0)));

  assert_seq_range_R3: assert property (@(posedge clk) disable iff (rst)
    seq_o <= CNT_W'(66));

  // R4: low ready is followed by a pause count on the sequence output.
  assert_ready_pause_R4: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> (seq_o == CNT_W'(21)) || (seq_o == CNT_W'(44)) ||
                 (seq_o == CNT_W'(65)) || (seq_o == CNT_W'(31)));

  // R5: data and header do not move after a cycle with ready low.
  assert_hold_in_pause_R5: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> $stable(data_o) && $stable(hdr_o));

endmodule

bind gbx_seq_ctrl gbx_seq_ctrl_chk #(.CNT_W(CNT_W), .D_W(D_W), .H_W(H_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .seq_o   (seq_o),
  .data_o  (data_o),
  .hdr_o   (hdr_o),
  .ready_o (ready_o)
);

// File: tb/gbx_seq_ctrl_bench.sv
`timescale 1ns/1ps
module gbx_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel_i = 1'b1;
  logic [15:0] up_data_i = '0;
  logic [2:0]  up_hdr_i = '0;
  logic [6:0]  seq_o;
  logic [15:0] data_o;
  logic [2:0]  hdr_o;
  logic        ready_o;

  always #2.5 clk = ~clk;

  gbx_seq_ctrl u_gbx_seq_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mode_sel_i (mode_sel_i),
    .up_data_i  (up_data_i),
    .up_hdr_i   (up_hdr_i),
    .seq_o      (seq_o),
    .data_o     (data_o),
    .hdr_o      (hdr_o),
    .ready_o    (ready_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state of the bench
  bit        m_mode;
  int        m_cnt;
  bit        m_ph;
  bit        m_half;
  int        e_seq;
  bit [15:0] e_data;
  bit [2:0]  e_hdr;
  bit        e_rdy;

  function automatic bit pause_at(bit mode67, int c);
    if (mode67) return (c == 21) || (c == 44) || (c == 65);
    return c == 31;
  endfunction

  function automatic int wrap_at(bit mode67);
    return mode67 ? 66 : 32;
  endfunction

  function automatic bit [2:0] hmask(bit mode67, bit [2:0] h);
    return mode67 ? h : {1'b0, h[1:0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit mode, bit [15:0] d, bit [2:0] h);
    bit p;
    bit was_pause;
    bit was_ph;
    bit wrapped;
    rst = r; mode_sel_i = mode; up_data_i = d; up_hdr_i = h;
    was_pause = 0; wrapped = 0; was_ph = m_ph;
    if (r) begin
      m_mode = mode; m_cnt = 0; m_ph = 0; m_half = 0;
      e_seq = 0; e_data = d; e_hdr = hmask(mode, h); e_rdy = 1;
    end else begin
      e_seq = m_cnt;
      p = pause_at(m_mode, m_cnt);
      was_pause = p;
      if (!p) e_data = d;
      if (!p && !m_ph && !m_half) e_hdr = hmask(m_mode, h);
      if (m_ph) begin
        if (m_cnt == wrap_at(m_mode)) begin
          m_cnt = 0; m_half = 0; wrapped = 1;
        end else begin
          if (!p) m_half = !m_half;
          m_cnt++;
        end
      end
      m_ph = !m_ph;
      e_rdy = !pause_at(m_mode, m_cnt);
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      chk("R1 seq", seq_o, 0);
      chk("R1 ready", ready_o, 1);
      chk("R1 data", data_o, e_data);
      chk("R1 hdr", hdr_o, e_hdr);
    end else begin
      chk(was_ph ? "R2 seq hold" : "R2 seq step", seq_o, e_seq);
      if (wrapped) chk("R3 wrap", seq_o, e_seq);
      chk("R4 ready", ready_o, e_rdy);
      chk(was_pause ? "R5 data held" : "R6 data", data_o, e_data);
      if (was_pause) chk("R5 hdr held", hdr_o, e_hdr);
      else if (!m_mode) chk("R7 hdr 66b", hdr_o, e_hdr);
      else chk("R6 hdr", hdr_o, e_hdr);
    end
  endtask

  // R8: mode_sel_i toggles at random outside reset
  task automatic run(int n, bit mode67);
    for (int i = 0; i < n; i++)
      step(0, ($urandom % 4 == 0) ? !mode67 : mode67,
           16'($urandom), 3'($urandom));
  endtask

  task automatic hold_reset(int n, bit mode67);
    for (int i = 0; i < n; i++)
      step(1, mode67, 16'($urandom), 3'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    hold_reset(4, 1);
    // Directed: first header and word at count 0 in 64B/67B
    step(0, 1, 16'hA5A5, 3'b101);
    chk("R6 first hdr", hdr_o, 3'b101);
    chk("R2 first seq", seq_o, 0);
    run(400, 1);
    hold_reset(3, 0);
    run(250, 0);
    hold_reset(25, 0);
    // Directed: 64B/66B header bit 2 is masked
    step(0, 1, 16'h1234, 3'b111);
    chk("R7 masked", hdr_o, 3'b011);
    chk("R8 mode kept", seq_o, 0);
    run(150, 0);
    hold_reset(2, 1);
    run(300, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule